// File: doc/BRIEF.md
# Center-Aligned PWM Period Counter

This block is the time base of a center-aligned PWM unit. A counter climbs from zero towards a programmable period, takes one extra step past it, turns around and falls back to zero, where it turns again. Because the turnaround sits one step above the period, the period value is crossed twice per PWM cycle: once on the way up and once on the way down.

Three registered event pulses come from that crossing, each with its own rule. The external trigger, meant for a converter or other outside consumer, pulses on both crossings. The internal event pulses only on the rising crossing; it serves interrupts and moves the shadow period into the active period. The pattern trigger gives one pulse per PWM cycle and can be used as a single-shot trigger source. By default it follows the rising crossing. A build-time option moves it to the bottom turnaround instead. Software writes the next period into a shadow register at any time. The new value takes effect at a clean point in the cycle. A run enable freezes the whole time base.

Top module: `cpwm_period_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `count` is 0, `dir_down` is 0 (counting up), and `trig_ext`, `evt_int` and `evt_pattern` are all 0.
- R2: While running and counting up, `count` rises by one per cycle until it reaches period+1. It then falls by one per cycle. With period 0x200 the values around the top are 0x1FE, 0x1FF, 0x200, 0x201, 0x200, 0x1FF, 0x1FE.
- R3: While running and counting down, `count` falls to 0, and in the next cycle it is 1 with the count direction up again.
- R4: `dir_down` is 1 exactly when the step that produced the current `count` was a decrement. It is 0 at period+1 and 1 at 0.
- R5: `trig_ext` is high for one cycle in each cycle where `count` has just become equal to the active period, whether reached while counting up or counting down. It therefore pulses twice per PWM cycle.
- R6: `evt_int` is high for one cycle only where `count` has just become equal to the active period while counting up (`dir_down` = 0). It pulses once per PWM cycle, and never without `trig_ext`.
- R7: With the default pattern option, `evt_pattern` pulses in exactly the cycles where `evt_int` pulses, once per PWM cycle. With the bottom option, it pulses once when `count` reaches 0 while counting down.
- R8: A cycle with `shadow_wr` = 1 stores `shadow_period`. On the clock edge that raises `evt_int`, the stored shadow value becomes the active period, and the turnaround that follows already uses the new value. After reset, both shadow and active period equal the parameter `RST_PERIOD`.
- R9: While `run_en` is 0, `count` and `dir_down` keep their values and no event output pulses. Counting resumes from the frozen state.
- R10: An active period of 0 acts as 1, and an active period of all ones acts as all ones minus 1, so the turnaround value period+1 always fits in `CNT_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Counter advances while 1, frozen while 0 |
| shadow_wr | input | 1 | Write strobe for the shadow period |
| shadow_period | input | CNT_W | Next period value, stored when `shadow_wr` is 1 |
| count | output | CNT_W | Current counter value |
| dir_down | output | 1 | 1 when the current value came from a downward step |
| trig_ext | output | 1 | One-cycle pulse on every period crossing |
| evt_int | output | 1 | One-cycle pulse on the upward period crossing only |
| evt_pattern | output | 1 | One-cycle pulse once per PWM cycle |

## Verification
The hardest case to reach is a shadow transfer that changes the turnaround. A lower period arrives while the counter already stands at the old period, so it must turn down at once. A higher period makes it keep climbing, so one rising crossing follows the transfer before any falling one. The stimulus writes the shadow register mid-cycle several times, going from 8 up to 0x200 and then down to 3. In these cases the cycle-accurate reference model must agree with the design on every clock through the irregular cycle. Both clamp limits are also driven through the shadow path: the all-ones case needs a run of about 65 thousand cycles to reach the top, so it is placed last.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   // Direction of the step that produced the current count value.
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } cnt_dir_e;

   // Where the once-per-cycle pattern trigger is taken from.
   typedef enum logic [0:0] {
      PAT_AT_PERIOD = 1'b0,
      PAT_AT_ZERO   = 1'b1
   } pat_src_e;

endpackage

// File: rtl/cpwm_period_regs.sv
module cpwm_period_regs #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned RST_PERIOD = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shadow_wr,
   input  logic [CNT_W-1:0] shadow_din,
   input  logic             xfer,
   output logic [CNT_W-1:0] eff_per
);

   localparam logic [CNT_W-1:0] PER_RST = CNT_W'(RST_PERIOD);
   localparam logic [CNT_W-1:0] PER_MIN = CNT_W'(1);
   localparam logic [CNT_W-1:0] PER_TOP = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] PER_MAX = {{(CNT_W-1){1'b1}}, 1'b0};

   logic [CNT_W-1:0] shadow_q;
   logic [CNT_W-1:0] active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= PER_RST;
      end else if (shadow_wr) begin
         shadow_q <= shadow_din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= PER_RST;
      end else if (xfer) begin
         active_q <= shadow_q;
      end
   end

   // Keep period+1 representable and never let the period collapse to zero.
   always_comb begin
      if (active_q == '0) begin
         eff_per = PER_MIN;
      end else if (active_q == PER_TOP) begin
         eff_per = PER_MAX;
      end else begin
         eff_per = active_q;
      end
   end

   p_eff_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_per != '0) && (eff_per != PER_TOP));

   p_xfer_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> (active_q == $past(shadow_q)));

   p_hold_no_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(active_q));

endmodule

// File: rtl/cpwm_updown_core.sv
module cpwm_updown_core
   import cpwm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] eff_per,
   output logic [CNT_W-1:0] cnt_q,
   output cnt_dir_e         dir_q,
   output logic [CNT_W-1:0] cnt_nx,
   output cnt_dir_e         dir_nx
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // Next-state: rise until above the period, fall until zero.
   always_comb begin
      cnt_nx = cnt_q;
      dir_nx = dir_q;
      if (step) begin
         if (dir_q == DIR_UP) begin
            if (cnt_q > eff_per) begin
               dir_nx = DIR_DOWN;
               cnt_nx = cnt_q - ONE;
            end else begin
               cnt_nx = cnt_q + ONE;
            end
         end else begin
            if (cnt_q == '0) begin
               dir_nx = DIR_UP;
               cnt_nx = ONE;
            end else begin
               cnt_nx = cnt_q - ONE;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= DIR_UP;
      end else begin
         cnt_q <= cnt_nx;
         dir_q <= dir_nx;
      end
   end

   p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE)));

   p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(cnt_q) && $stable(dir_q)));

   p_zero_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_q == '0) |=> (cnt_q == ONE && dir_q == DIR_UP));

   p_dir_matches_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> ((dir_q == DIR_DOWN) == (cnt_q == $past(cnt_q) - ONE)));

endmodule

// File: rtl/cpwm_event_gen.sv
module cpwm_event_gen
   import cpwm_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter pat_src_e    PAT_SRC = PAT_AT_PERIOD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt_nx,
   input  cnt_dir_e         dir_nx,
   input  logic [CNT_W-1:0] eff_per,
   input  logic [CNT_W-1:0] cnt_q,
   output logic             xfer,
   output logic             ext_q,
   output logic             int_q,
   output logic             pat_q
);

   logic hit_any;
   logic hit_up;
   logic pat_d;

   assign hit_any = step && (cnt_nx == eff_per);
   assign hit_up  = hit_any && (dir_nx == DIR_UP);
   assign xfer    = hit_up;

   generate
      if (PAT_SRC == PAT_AT_PERIOD) begin : g_pat_period
         assign pat_d = hit_up;
      end else begin : g_pat_zero
         assign pat_d = step && (cnt_nx == '0) && (dir_nx == DIR_DOWN);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q <= 1'b0;
         int_q <= 1'b0;
         pat_q <= 1'b0;
      end else begin
         ext_q <= hit_any;
         int_q <= hit_up;
         pat_q <= pat_d;
      end
   end

   p_ext_at_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ext_q |-> (cnt_q == $past(eff_per)));

   p_int_needs_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int_q |-> ext_q);

   p_no_events_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> (!ext_q && !int_q && !pat_q));

   generate
      if (PAT_SRC == PAT_AT_PERIOD) begin : g_chk_period
         p_pat_with_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
            pat_q == int_q);
      end else begin : g_chk_zero
         p_pat_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            pat_q |-> (cnt_q == '0));
      end
   endgenerate

endmodule

// File: rtl/cpwm_period_timer.sv
module cpwm_period_timer
   import cpwm_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned RST_PERIOD = 8,
   parameter pat_src_e    PAT_SRC    = PAT_AT_PERIOD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             shadow_wr,
   input  logic [CNT_W-1:0] shadow_period,
   output logic [CNT_W-1:0] count,
   output logic             dir_down,
   output logic             trig_ext,
   output logic             evt_int,
   output logic             evt_pattern
);

   localparam longint unsigned PER_LIMIT = (64'd1 << CNT_W) - 64'd2;

   generate
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_width
         $error("cpwm_period_timer: CNT_W must lie in 2..31");
      end
      if (RST_PERIOD < 1 || longint'(RST_PERIOD) > PER_LIMIT) begin : g_bad_rst
         $error("cpwm_period_timer: RST_PERIOD outside the usable range");
      end
   endgenerate

   logic [CNT_W-1:0] eff_per;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;
   cnt_dir_e         dir_q;
   cnt_dir_e         dir_nx;
   logic             xfer;

   cpwm_period_regs #(
      .CNT_W      (CNT_W),
      .RST_PERIOD (RST_PERIOD)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .shadow_wr  (shadow_wr),
      .shadow_din (shadow_period),
      .xfer       (xfer),
      .eff_per    (eff_per)
   );

   cpwm_updown_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (run_en),
      .eff_per (eff_per),
      .cnt_q   (cnt_q),
      .dir_q   (dir_q),
      .cnt_nx  (cnt_nx),
      .dir_nx  (dir_nx)
   );

   cpwm_event_gen #(
      .CNT_W   (CNT_W),
      .PAT_SRC (PAT_SRC)
   ) u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (run_en),
      .cnt_nx  (cnt_nx),
      .dir_nx  (dir_nx),
      .eff_per (eff_per),
      .cnt_q   (cnt_q),
      .xfer    (xfer),
      .ext_q   (trig_ext),
      .int_q   (evt_int),
      .pat_q   (evt_pattern)
   );

   assign count    = cnt_q;
   assign dir_down = (dir_q == DIR_DOWN);

   p_top_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !dir_down && count > eff_per) |=> dir_down);

endmodule

// File: tb/cpwm_period_timer_tb.sv
module cpwm_period_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        shadow_wr = 1'b0;
   logic [15:0] shadow_period = '0;
   logic [15:0] count;
   logic        dir_down;
   logic        trig_ext;
   logic        evt_int;
   logic        evt_pattern;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // reference model state
   int unsigned m_cnt = 0;
   bit          m_dn  = 0;
   bit          m_ext = 0;
   bit          m_int = 0;
   bit          m_pat = 0;
   int unsigned m_act = 8;
   int unsigned m_shd = 8;

   // directed bookkeeping
   bit          capture = 0;
   logic [15:0] hist[$];
   int          ints_since_wr = 0;
   int          ext_since = 0;
   int unsigned max_seen = 0;

   always #2 clk = ~clk;

   cpwm_period_timer #(
      .CNT_W      (16),
      .RST_PERIOD (8)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .run_en        (run_en),
      .shadow_wr     (shadow_wr),
      .shadow_period (shadow_period),
      .count         (count),
      .dir_down      (dir_down),
      .trig_ext      (trig_ext),
      .evt_int       (evt_int),
      .evt_pattern   (evt_pattern)
   );

   function automatic int unsigned clamp_per(input int unsigned v);
      if (v == 0) return 1;
      if (v == 16'hFFFF) return 16'hFFFE;
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int unsigned act, input int unsigned exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic model_step(input bit run, input bit wr, input int unsigned val);
      int unsigned e;
      e = clamp_per(m_act);
      m_ext = 0; m_int = 0; m_pat = 0;
      if (run) begin
         if (!m_dn) begin
            if (m_cnt > e) begin m_dn = 1; m_cnt = m_cnt - 1; end
            else m_cnt = m_cnt + 1;
         end else begin
            if (m_cnt == 0) begin m_dn = 0; m_cnt = 1; end
            else m_cnt = m_cnt - 1;
         end
         if (m_cnt == e) begin
            m_ext = 1;
            if (!m_dn) begin m_int = 1; m_pat = 1; end
         end
      end
      if (m_int) m_act = m_shd;
      if (wr) m_shd = val;
   endtask

   task automatic compare_all();
      check(count == 16'(m_cnt), "R2/R3", "count", count, m_cnt);
      check(dir_down == m_dn, "R4", "dir_down", dir_down, m_dn);
      check(trig_ext == m_ext, "R5", "trig_ext", trig_ext, m_ext);
      check(evt_int == m_int, "R6", "evt_int", evt_int, m_int);
      check(evt_pattern == m_pat, "R7", "evt_pattern", evt_pattern, m_pat);
      if (capture) hist.push_back(count);
      if (count > max_seen) max_seen = count;
      // R5/R6: two external triggers per internal event in steady cycles
      if (evt_int) begin
         ints_since_wr++;
         if (ints_since_wr >= 3)
            check(ext_since == 2, "R5", "ext per cycle", ext_since, 2);
         ext_since = 0;
      end
      if (trig_ext) ext_since++;
   endtask

   task automatic tick(input bit run, input bit wr, input logic [15:0] val);
      run_en = run; shadow_wr = wr; shadow_period = val;
      @(posedge clk);
      model_step(run, wr, val);
      @(negedge clk);
      compare_all();
      if (wr) ints_since_wr = 0;
   endtask

   task automatic run_n(input int n);
      for (int i = 0; i < n; i++) tick(1'b1, 1'b0, '0);
   endtask

   initial begin
      logic [15:0] top_seq[7];
      int found;
      top_seq = '{16'h1FE, 16'h1FF, 16'h200, 16'h201, 16'h200, 16'h1FF, 16'h1FE};

      // R1: reset state
      repeat (3) @(negedge clk);
      check(count == 0 && !dir_down, "R1", "reset count/dir", {dir_down, count}, 0);
      check(!trig_ext && !evt_int && !evt_pattern, "R1", "reset pulses",
            {trig_ext, evt_int, evt_pattern}, 0);
      rst_n = 1'b1;
      tick(1'b0, 1'b0, '0);
      check(count == 0 && !dir_down, "R1", "first cycle after reset", count, 0);

      // R2/R3/R5/R6/R7 with reset period 8
      run_n(60);

      // R9: pause mid-count, also write shadow while frozen
      begin
         logic [15:0] held;
         logic        held_dir;
         held = count; held_dir = dir_down;
         tick(1'b0, 1'b1, 16'h200);
         for (int i = 0; i < 15; i++) tick(1'b0, 1'b0, '0);
         check(count == held && dir_down == held_dir, "R9", "frozen state", count, held);
      end

      // R8: shadow 0x200 takes effect at next upward crossing; R2 sequence
      capture = 1;
      run_n(3200);
      capture = 0;
      found = 0;
      for (int i = 0; i + 6 < hist.size(); i++) begin
         if (found == 0 && hist[i] == 16'h1FE && hist[i+1] == 16'h1FF) begin
            found = 1;
            for (int k = 0; k < 7; k++)
               check(hist[i+k] == top_seq[k], "R2", "top sequence", hist[i+k], top_seq[k]);
         end
      end
      check(found == 1, "R2", "top sequence found", found, 1);
      found = 0;
      for (int i = 0; i + 2 < hist.size(); i++) begin
         if (found == 0 && hist[i] == 1 && hist[i+1] == 0) begin
            found = 1;
            check(hist[i+2] == 1, "R3", "bottom turnaround", hist[i+2], 1);
         end
      end
      check(found == 1, "R3", "bottom found", found, 1);
      check(max_seen == 16'h201, "R8", "max count at period 0x200", max_seen, 16'h201);

      // R8: lower the period mid-cycle
      tick(1'b1, 1'b1, 16'd3);
      run_n(1200);
      max_seen = 0;
      run_n(40);
      check(max_seen == 4, "R8", "max count at period 3", max_seen, 4);

      // R10: zero period acts as one
      tick(1'b1, 1'b1, 16'd0);
      run_n(30);
      max_seen = 0;
      run_n(20);
      check(max_seen == 2, "R10", "max count at period 0", max_seen, 2);

      // R10: all-ones period acts as all-ones minus one
      tick(1'b1, 1'b1, 16'hFFFF);
      run_n(10);
      max_seen = 0;
      run_n(65560);
      check(max_seen == 16'hFFFF, "R10", "max count at all-ones period", max_seen, 16'hFFFF);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule